// File: doc/BRIEF.md
# Count-Min Hot Page Detector

This block watches the access stream aimed at the slow memory tier and works out which pages are used often enough to be worth moving to the fast tier. Each accepted access is hashed into two independent lanes of saturating counters. The smaller of the page's two counts is the page's estimated access frequency. When that estimate reaches a programmable threshold and the page has not been reported yet, the page number is queued in a small candidate FIFO for the migration logic.

A controller with two states alternates between counting and clearing. `ST_SWEEP` walks an index across every counter and every hot flag and zeroes one entry per cycle. `ST_RUN` counts accesses. The controller goes from `ST_SWEEP` to `ST_RUN` when the sweep index reaches its last entry. It goes from `ST_RUN` to `ST_SWEEP` when the run-cycle tick reaches the programmed interval. Reset enters `ST_SWEEP`, so the tables are zeroed before the first count. The update path has two stages: stage 1 registers the page and the table reads, and stage 2 increments the counters, tests the threshold and pushes the candidate. Reads in stage 1 are forwarded from the stage 2 write, so accesses that hit the same counters in consecutive cycles are all counted.

Top module: `hps_top`

## Requirements
- R1: Lane 0 index is ((page*725) mod 1024) XOR (page>>2). Lane 1 index is ((page*423) mod 1024) XOR (page>>5). Each accepted access adds one to both indexed counters. The counters are 8 bits and hold at 255.
- R2: The estimate is the minimum of the two incremented counts. A page whose estimate is at least `hot_thr` and whose hot flag is clear is pushed into the FIFO. An access presented in cycle c shows on `cand_valid`/`cand_page` in cycle c+2.
- R3: A page that was pushed has its hot flag set. It is not pushed again until the next clear.
- R4: When the FIFO is full (4 entries), a qualifying page is dropped and its flag stays clear. A later access to that page reports it again.
- R5: Accesses with `acc_slow`=0 change no counter and no flag.
- R6: Accesses in consecutive cycles that share counters or a hot flag are all counted; none is lost.
- R7: After reset, and after every `clr_interval` run cycles, `sweeping` is 1 for exactly 1024 cycles. Accesses during the sweep, and in the last run cycle before it, are dropped. After the sweep, all counts and flags are zero.
- R8: Candidates leave in the order they were pushed. `cand_page` holds while `cand_valid`=1 and `cand_ready`=0. A pop happens on a clock edge where both are 1.
- R9: During and right after reset, `sweeping`=1 and `cand_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_slow | input | 1 | The access targets the slow tier |
| acc_page | input | 10 | Page number of the access |
| hot_thr | input | 8 | Hot threshold for the estimate |
| clr_interval | input | 32 | Run cycles between clears (at least 1) |
| cand_ready | input | 1 | Consumer takes the head candidate |
| cand_valid | output | 1 | The FIFO holds a candidate |
| cand_page | output | 10 | Head candidate page number |
| sweeping | output | 1 | Controller is in `ST_SWEEP` |

## Verification
The hardest case to reach is a candidate dropped on a full FIFO and then reported again. It needs `cand_ready` held low while five distinct pages reach the threshold in an interleaved order, then a drain, then one more access to the dropped page. The bench drives exactly this sequence with pages whose lane 0 indices are all distinct, so the order of reports is known. A same-page burst on consecutive cycles exercises the forwarding path. Shortening `clr_interval` while the tick counter is already past the new value forces an immediate clear. Random traffic over a narrow page range, with the cycle-accurate model compared on every clock, covers hash collisions and repeated clears.

// File: rtl/hps_pkg.sv
package hps_pkg;
    typedef enum logic {ST_SWEEP, ST_RUN} hps_state_e;

    localparam int LANES = 2;
    localparam logic [31:0] HASH_MUL [LANES] = '{32'd725, 32'd423};
    localparam int          HASH_SH  [LANES] = '{2, 5};

    // multiplicative hash folded with a shifted copy of the page number
    function automatic logic [31:0] hps_hash(input logic [31:0] page,
                                             input logic [31:0] mul,
                                             input int          sh);
        return (page * mul) ^ (page >> sh);
    endfunction
endpackage

// File: rtl/hps_table.sv
// One lane of state: synchronous read with forwarding from a same-cycle write,
// plus a sweep port that zeroes one entry per cycle.
module hps_table #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_q,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);
    localparam int ENTRIES = 2 ** IDX_W;

    logic [DATA_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (clr_en)
            mem[clr_idx] <= '0;
        else if (wr_en)
            mem[wr_idx] <= wr_data;
        rd_q <= (wr_en && wr_idx == rd_idx) ? wr_data : mem[rd_idx];
    end
endmodule

// File: rtl/hps_fifo.sv
module hps_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    input  logic         pop_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign full      = cnt_q == (AW+1)'(DEPTH);
    assign out_valid = cnt_q != '0;
    assign out_data  = slots[rp_q];
    assign do_push   = push && !full;
    assign do_pop    = out_valid && pop_ready;

    always_ff @(posedge clk) begin
        if (do_push) slots[wp_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + AW'(1);
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + AW'(1);
            cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/hps_ctrl.sv
module hps_ctrl
    import hps_pkg::*;
#(
    parameter int SWEEP_N = 1024,
    parameter int SW_W    = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     interval,
    output logic            run,
    output logic            sweeping,
    output logic [SW_W-1:0] sweep_idx
);
    hps_state_e      state_q, state_d;
    logic [SW_W-1:0] sw_q;
    logic [31:0]     tick_q;
    logic            last_sweep, tick_done;

    assign last_sweep = sw_q == SW_W'(SWEEP_N-1);
    assign tick_done  = tick_q >= interval - 32'd1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP: if (last_sweep) state_d = ST_RUN;
            ST_RUN:   if (tick_done)  state_d = ST_SWEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SWEEP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q   <= '0;
            tick_q <= '0;
        end else begin
            unique case (state_q)
                ST_SWEEP: begin
                    sw_q   <= last_sweep ? '0 : sw_q + SW_W'(1);
                    tick_q <= '0;
                end
                ST_RUN: begin
                    sw_q   <= '0;
                    tick_q <= tick_done ? '0 : tick_q + 32'd1;
                end
            endcase
        end
    end

    always_comb begin
        run       = 1'b0;
        sweeping  = 1'b0;
        sweep_idx = sw_q;
        unique case (state_q)
            ST_SWEEP: sweeping = 1'b1;
            ST_RUN:   run      = 1'b1;
        endcase
    end
endmodule

// File: rtl/hps_top.sv
module hps_top
    import hps_pkg::*;
#(
    parameter int PAGE_W     = 10,
    parameter int IDX_W      = 10,
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_slow,
    input  logic [PAGE_W-1:0] acc_page,
    input  logic [CNT_W-1:0]  hot_thr,
    input  logic [31:0]       clr_interval,
    input  logic              cand_ready,
    output logic              cand_valid,
    output logic [PAGE_W-1:0] cand_page,
    output logic              sweeping
);
    localparam int SWEEP_N = (IDX_W > PAGE_W) ? 2 ** IDX_W : 2 ** PAGE_W;
    localparam int SW_W    = $clog2(SWEEP_N);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              run;
    logic [SW_W-1:0]   sweep_idx;
    logic              s1_v;
    logic [PAGE_W-1:0] s1_page;
    logic              s2_go, push, fifo_full;
    logic [CNT_W-1:0]  cnt_q [LANES];
    logic [CNT_W-1:0]  cnt_n [LANES];
    logic [CNT_W-1:0]  est;
    logic              flag_q;

    hps_ctrl #(.SWEEP_N(SWEEP_N), .SW_W(SW_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .interval(clr_interval),
        .run(run), .sweeping(sweeping), .sweep_idx(sweep_idx)
    );

    // stage 1: register the access; tables read in the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_page <= '0;
        end else begin
            s1_v    <= run && acc_valid && acc_slow;
            s1_page <= acc_page;
        end
    end

    assign s2_go = s1_v && run;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IDX_W-1:0] rd_idx, wr_idx;
        assign rd_idx   = IDX_W'(hps_hash(32'(acc_page), HASH_MUL[g], HASH_SH[g]));
        assign wr_idx   = IDX_W'(hps_hash(32'(s1_page),  HASH_MUL[g], HASH_SH[g]));
        assign cnt_n[g] = (cnt_q[g] == CNT_MAX) ? cnt_q[g] : cnt_q[g] + CNT_W'(1);

        hps_table #(.DATA_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
            .clk(clk), .rd_idx(rd_idx), .rd_q(cnt_q[g]),
            .wr_en(s2_go), .wr_idx(wr_idx), .wr_data(cnt_n[g]),
            .clr_en(sweeping), .clr_idx(sweep_idx[IDX_W-1:0])
        );
    end

    hps_table #(.DATA_W(1), .IDX_W(PAGE_W)) u_flag (
        .clk(clk), .rd_idx(acc_page), .rd_q(flag_q),
        .wr_en(push), .wr_idx(s1_page), .wr_data(1'b1),
        .clr_en(sweeping), .clr_idx(sweep_idx[PAGE_W-1:0])
    );

    // stage 2: estimate, threshold, duplicate filter
    assign est  = (cnt_n[0] < cnt_n[1]) ? cnt_n[0] : cnt_n[1];
    assign push = s2_go && (est >= hot_thr) && !flag_q && !fifo_full;

    hps_fifo #(.W(PAGE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(s1_page),
        .full(fifo_full), .pop_ready(cand_ready),
        .out_valid(cand_valid), .out_data(cand_page)
    );
endmodule

// File: rtl/hps_chk.sv
module hps_chk #(
    parameter int SWEEP_N = 1024,
    parameter int CNT_W   = 8,
    parameter int PAGE_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sweeping,
    input logic              push,
    input logic              fifo_full,
    input logic [CNT_W-1:0]  est,
    input logic [CNT_W-1:0]  hot_thr,
    input logic              cand_valid,
    input logic              cand_ready,
    input logic [PAGE_W-1:0] cand_page
);
    logic [31:0] scnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        scnt <= '0;
        else if (sweeping) scnt <= scnt + 32'd1;
        else               scnt <= '0;
    end

    AST_NO_PUSH_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sweeping |-> !push); // R7
    AST_SWEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sweeping && scnt < 32'(SWEEP_N-1)) |=> sweeping); // R7
    AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (sweeping && scnt == 32'(SWEEP_N-1)) |=> !sweeping); // R7
    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !fifo_full); // R4
    AST_PUSH_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> est >= hot_thr); // R2
    AST_CAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && !cand_ready) |=> (cand_valid && $stable(cand_page))); // R8
endmodule

bind hps_top hps_chk #(.SWEEP_N(SWEEP_N), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sweeping(sweeping), .push(push),
    .fifo_full(fifo_full), .est(est), .hot_thr(hot_thr),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_page(cand_page)
);

// File: tb/sim_hps_top.sv
module sim_hps_top;
    localparam int NPG = 1024;
    localparam int SWN = 1024;
    localparam int FD  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_slow = 1'b0, cand_ready = 1'b0;
    logic [9:0]  acc_page = '0;
    logic [7:0]  hot_thr = 8'd3;
    logic [31:0] clr_interval = 32'd1000000;
    logic        cand_valid, sweeping;
    logic [9:0]  cand_page;

    int checks = 0, errors = 0, cyc = 0;
    string tag = "R9";

    hps_top u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_slow(acc_slow),
        .acc_page(acc_page), .hot_thr(hot_thr), .clr_interval(clr_interval),
        .cand_ready(cand_ready), .cand_valid(cand_valid), .cand_page(cand_page),
        .sweeping(sweeping)
    );

    always #5 clk = ~clk;

    // ---------------- reference model ----------------
    int   c0 [NPG];
    int   c1 [NPG];
    bit   flg [NPG];
    int   q [$];
    bit   m_clear = 1'b1, p_v = 1'b0;
    int   p_page = 0, m_sweep = 0;
    bit [31:0] m_tick = '0;

    function automatic int hidx(int p, int lane);
        if (lane == 0) return ((p * 725) % 1024) ^ (p >> 2);
        return ((p * 423) % 1024) ^ (p >> 5);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clear = 1'b1; m_sweep = 0; m_tick = '0; p_v = 1'b0;
            q.delete();
            for (int i = 0; i < NPG; i++) begin c0[i] = 0; c1[i] = 0; flg[i] = 0; end
        end else begin
            bit run_now, do_push;
            run_now = !m_clear;
            do_push = 1'b0;
            if (run_now && p_v) begin
                int a, b, e;
                a = hidx(p_page, 0); b = hidx(p_page, 1);
                if (c0[a] < 255) c0[a]++;
                if (c1[b] < 255) c1[b]++;
                e = (c0[a] < c1[b]) ? c0[a] : c1[b];
                if (e >= int'(hot_thr) && !flg[p_page] && q.size() < FD) do_push = 1'b1;
            end
            if (q.size() > 0 && cand_ready) void'(q.pop_front());
            if (do_push) begin q.push_back(p_page); flg[p_page] = 1'b1; end
            p_v    = run_now && acc_valid && acc_slow;
            p_page = int'(acc_page);
            if (m_clear) begin
                if (m_sweep == SWN - 1) begin m_clear = 1'b0; m_tick = '0; m_sweep = 0; end
                else m_sweep++;
            end else if (m_tick >= clr_interval - 32'd1) begin
                m_clear = 1'b1; m_sweep = 0;
                for (int i = 0; i < NPG; i++) begin c0[i] = 0; c1[i] = 0; flg[i] = 0; end
            end else m_tick++;
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(sweeping), int'(m_clear), tag, "sweeping vs model");
            chk(int'(cand_valid), int'(q.size() > 0), tag, "cand_valid vs model");
            if (cand_valid && q.size() > 0) chk(int'(cand_page), q[0], tag, "cand_page vs model");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input int p, input bit slow);
        @(negedge clk);
        acc_valid = 1'b1; acc_slow = slow; acc_page = 10'(p);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_valid = 1'b0;
        end
    endtask

    task automatic pop1();
        @(negedge clk); acc_valid = 1'b0; cand_ready = 1'b1;
        @(negedge clk); cand_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(int'(sweeping), 1, "R9", "sweeping in reset");
        chk(int'(cand_valid), 0, "R9", "cand_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(sweeping), 1, "R9", "sweeping after reset");
        while (sweeping) @(negedge clk);

        tag = "R5";
        for (int i = 0; i < 5; i++) drive(5, 1'b0);
        drive(5, 1'b1); drive(5, 1'b1);
        idle(3);
        chk(int'(cand_valid), 0, "R5", "non-slow accesses counted");
        drive(5, 1'b1); idle(2);
        chk(int'(cand_valid), 1, "R5", "third slow access reports");
        chk(int'(cand_page), 5, "R5", "reported page");
        pop1();

        tag = "R2";
        drive(7, 1'b1); idle(2); drive(7, 1'b1); idle(3);
        chk(int'(cand_valid), 0, "R1", "below threshold");
        drive(7, 1'b1); idle(1);
        chk(int'(cand_valid), 0, "R2", "one cycle after access");
        idle(1);
        chk(int'(cand_valid), 1, "R2", "two cycles after access");
        chk(int'(cand_page), 7, "R2", "reported page");
        pop1();

        tag = "R6";
        for (int i = 0; i < 4; i++) drive(9, 1'b1);
        idle(2);
        chk(int'(cand_valid), 1, "R6", "back-to-back burst reports");
        chk(int'(cand_page), 9, "R6", "reported page");
        pop1(); idle(3);
        chk(int'(cand_valid), 0, "R3", "single report per burst");
        tag = "R3";
        for (int i = 0; i < 3; i++) drive(9, 1'b1);
        idle(3);
        chk(int'(cand_valid), 0, "R3", "flagged page not reported again");

        tag = "R4";
        for (int r = 0; r < 3; r++)
            for (int p = 20; p < 25; p++) drive(p, 1'b1);
        idle(3);
        for (int i = 0; i < 4; i++) begin
            chk(int'(cand_page), 20 + i, "R8", "FIFO order");
            pop1();
        end
        chk(int'(cand_valid), 0, "R4", "fifth candidate dropped when full");
        drive(24, 1'b1); idle(2);
        chk(int'(cand_valid), 1, "R4", "dropped page reported later");
        chk(int'(cand_page), 24, "R4", "reported page");
        pop1();
        drive(20, 1'b1); idle(3);
        chk(int'(cand_valid), 0, "R3", "flag kept after pop");

        tag = "R7";
        clr_interval = 32'd50;
        idle(2);
        chk(int'(sweeping), 1, "R7", "clear starts at shortened interval");
        while (sweeping) @(negedge clk);
        drive(9, 1'b1); drive(9, 1'b1); idle(3);
        chk(int'(cand_valid), 0, "R7", "counts zero after sweep");
        drive(9, 1'b1); idle(2);
        chk(int'(cand_valid), 1, "R7", "flag cleared by sweep");
        chk(int'(cand_page), 9, "R7", "reported page");
        pop1();

        tag = "R1";
        hot_thr = 8'd4;
        clr_interval = 32'd300;
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            acc_valid  = ($urandom_range(0, 9) < 7);
            acc_slow   = ($urandom_range(0, 9) < 8);
            acc_page   = ($urandom_range(0, 3) == 0) ? 10'($urandom_range(0, 1023))
                                                     : 10'($urandom_range(0, 40));
            cand_ready = $urandom_range(0, 1) == 1;
        end
        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule